// File: doc/BRIEF.md
# Clock-Handshaking Synchronous Serial Channel

This block is one channel of a byte-wide synchronous serial link. Configuration inputs make it a master, which drives the shift clock, or a slave, which follows a clock from the pin. They also make it a transmitter or a receiver. One data register serves as both the transmit buffer and the receive buffer. Eight bits move per transfer, most significant bit first, with one clock pulse per bit. Both the clock pin and the data pin have separate in, out and output-enable signals, so the pad ring can build tri-state or open-drain pins around them.

In normal mode the clock rests low. The receiver captures on the edge that leaves the rest level and the transmitter launches the next bit on the edge that returns to it. In handshaking mode the polarity is inverted: the clock rests high through an external pull-up, and each side only ever pulls the line low. A slave that cannot take or supply a byte holds the line low. A master starts a byte only when it sees the line high at a bit-rate tick. A master spends exactly one tick period in each clock half-period. A slave resynchronises the pin into the system-clock domain, so its clock must stay at or below a quarter of the system clock.

Each finished byte raises a sticky pending flag. A mask input gates that flag onto the interrupt output.

Top module: `sync_serial_chan`

## Requirements
- R1: After reset the buffer is empty (`buf_full`=0), `pend` and `irq` are 0, and while `en`=0 neither `sc_oe` nor `sd_oe` is asserted.
- R2: In normal mode, an enabled master transmitter with a loaded buffer produces exactly 8 high pulses on `sc_o` and drives the byte MSB first on `sd_o`. `sd_o` changes only when `sc_o` falls. After the byte, `sc_o` rests low and `sd_oe` is 0.
- R3: In normal mode, a master receiver captures `sd_i` at each rising `sc_o` edge, MSB first, then shows the byte on `rd_data` with `buf_full`=1. It starts no new byte while `buf_full`=1.
- R4: A master changes its clock level only in the cycle after a `tick` pulse, so each clock half-period lasts exactly one tick interval.
- R5: A finished byte sets `pend`. A finished transmission clears `buf_full`. `pend` stays set until `pend_clr`. `irq` equals `pend` gated by `irq_mask`.
- R6: In normal mode, a slave receiver shifts in the synchronised `sd_i` on each rising edge of the synchronised `sc_i`, and after 8 bits presents the byte with `buf_full`=1 and `pend`=1.
- R7: A slave transmitter drives its MSB on `sd_o` (`sd_oe`=1) as soon as it is enabled with a loaded buffer. It shifts on each falling edge of `sc_i` and releases `sd_oe` after the 8th falling edge.
- R8: In handshaking mode, a master pulls the clock low (`sc_oe`=1) for the active half of each bit and releases it (`sc_oe`=0) otherwise. It starts a byte only at a tick where the synchronised `sc_i` is high, so it waits while another device holds the line low.
- R9: In handshaking mode, a slave pulls the clock low while busy: a receiver while `buf_full`=1, a transmitter while `buf_full`=0. It releases the line as soon as it becomes ready.
- R10: A `wr_en` that arrives while a byte is moving has no effect on the byte or on `buf_full`.
- R11: Dropping `en` abandons any transfer. On the next cycle `sc_o` is 0 and both output enables are 0.
- R12: In handshaking mode `sc_o` is always 0, so the clock pin acts as open-drain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Bit-rate tick; one pulse per clock half-period |
| en | input | 1 | Channel enable |
| master | input | 1 | 1 = drive the clock, 0 = follow the pin clock |
| xmit | input | 1 | 1 = transmitter, 0 = receiver |
| hs | input | 1 | 1 = handshaking mode (inverted, open-drain clock) |
| irq_mask | input | 1 | Lets `pend` reach `irq` |
| pend_clr | input | 1 | Clears the pending flag |
| wr_en | input | 1 | Loads `wr_data` into the buffer and marks it full |
| wr_data | input | DATA_W | Byte to transmit |
| rd_en | input | 1 | Marks the buffer empty |
| rd_data | output | DATA_W | Buffer contents |
| buf_full | output | 1 | Buffer status |
| pend | output | 1 | Transfer-done pending flag |
| irq | output | 1 | Masked interrupt |
| sc_i | input | 1 | Clock pin input |
| sc_o | output | 1 | Clock pin output value |
| sc_oe | output | 1 | Clock pin output enable |
| sd_i | input | 1 | Data pin input |
| sd_o | output | 1 | Data pin output value |
| sd_oe | output | 1 | Data pin output enable |

## Verification
The properties assume that `master`, `xmit` and `hs` change only while `en` is low, and that `wr_en` never lands in the middle of a byte except where that write is meant to be ignored. The stimulus respects this by reconfiguring the channel only after clearing `en`. The bench models the external pull-up as a wired-AND of the block's own pull-down and a pull-down driven by the bench. In handshaking mode the bench spaces ticks eight system clocks apart. When it plays the remote master, it holds each half-period for six system clocks, which keeps the slave's pin clock within a quarter of the system clock.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    // depth of the pin resynchroniser
    localparam int SSC_SYNC_STAGES = 2;

    // a slave cannot proceed: a receiver holding an unread byte,
    // or a transmitter with nothing loaded
    function automatic logic ssc_busy(input logic xmit, input logic full);
        return xmit ? ~full : full;
    endfunction

endpackage

// File: rtl/ssc_sync.sv
module ssc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    output logic             rise,
    output logic             fall
);

    // one extra stage holds the previous value for edge detection on bit 0
    logic [STAGES:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d = {stg_q[STAGES-1:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign q    = stg_q[STAGES-1];
    assign rise =  stg_q[STAGES-1][0] & ~stg_q[STAGES][0];
    assign fall = ~stg_q[STAGES-1][0] &  stg_q[STAGES][0];

endmodule

// File: rtl/ssc_irq.sv
module ssc_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic mask,
    output logic pend,
    output logic irq
);

    logic pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (clr) pend_d = 1'b0;
        if (set) pend_d = 1'b1;   // a completion wins over a clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pend = pend_q;
    assign irq  = pend_q & mask;

endmodule

// File: rtl/sync_serial_chan.sv
module sync_serial_chan
    import ssc_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = SSC_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              en,
    input  logic              master,
    input  logic              xmit,
    input  logic              hs,
    input  logic              irq_mask,
    input  logic              pend_clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              buf_full,
    output logic              pend,
    output logic              irq,
    input  logic              sc_i,
    output logic              sc_o,
    output logic              sc_oe,
    input  logic              sd_i,
    output logic              sd_o,
    output logic              sd_oe
);

    localparam int HCNT_W = $clog2(2 * DATA_W);
    localparam int BCNT_W = $clog2(DATA_W + 1);
    localparam logic [HCNT_W-1:0] LAST_HALF = HCNT_W'(2 * DATA_W - 1);
    localparam logic [BCNT_W-1:0] BITS      = BCNT_W'(DATA_W);

    typedef struct packed {
        logic [DATA_W-1:0] shreg;  // buffer and shifter in one
        logic              full;
        logic              mact;   // master byte in flight
        logic              sclk;   // master clock phase, 1 = active half
        logic [HCNT_W-1:0] hcnt;
        logic              sact;   // slave byte in flight
        logic [BCNT_W-1:0] bcnt;
    } chan_t;

    chan_t chan_d, chan_q;

    logic [1:0] sync_q;
    logic       line_s, sd_s, sc_rise, sc_fall;
    logic       samp_e, launch_e, busy, done;

    ssc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({sd_i, sc_i}),
        .q    (sync_q),
        .rise (sc_rise),
        .fall (sc_fall)
    );

    assign line_s = sync_q[0];
    assign sd_s   = sync_q[1];

    // capture on the edge leaving rest level, launch on the edge returning to it
    assign samp_e   = hs ? sc_fall : sc_rise;
    assign launch_e = hs ? sc_rise : sc_fall;
    assign busy     = en & hs & ~master & ssc_busy(xmit, chan_q.full);

    always_comb begin
        chan_d = chan_q;
        done   = 1'b0;

        if (!en) begin
            chan_d.mact = 1'b0;
            chan_d.sclk = 1'b0;
            chan_d.hcnt = '0;
            chan_d.sact = 1'b0;
            chan_d.bcnt = '0;
        end else if (master) begin
            if (!chan_q.mact) begin
                if (tick && (xmit ? chan_q.full : ~chan_q.full) && (!hs || line_s)) begin
                    chan_d.mact = 1'b1;
                    chan_d.hcnt = '0;
                end
            end else if (tick) begin
                chan_d.hcnt = chan_q.hcnt + 1'b1;
                if (!chan_q.sclk) begin
                    chan_d.sclk = 1'b1;
                    if (!xmit) chan_d.shreg = {chan_q.shreg[DATA_W-2:0], sd_i};
                end else begin
                    chan_d.sclk = 1'b0;
                    if (chan_q.hcnt == LAST_HALF) begin
                        done        = 1'b1;
                        chan_d.mact = 1'b0;
                        chan_d.hcnt = '0;
                        chan_d.full = ~xmit;
                    end else if (xmit) begin
                        chan_d.shreg = {chan_q.shreg[DATA_W-2:0], 1'b0};
                    end
                end
            end
        end else if (!busy) begin
            if (samp_e) begin
                chan_d.sact = 1'b1;
                if (chan_q.bcnt != BITS) chan_d.bcnt = chan_q.bcnt + 1'b1;
                if (!xmit) chan_d.shreg = {chan_q.shreg[DATA_W-2:0], sd_s};
            end else if (launch_e && chan_q.sact) begin
                if (chan_q.bcnt == BITS) begin
                    done        = 1'b1;
                    chan_d.sact = 1'b0;
                    chan_d.bcnt = '0;
                    chan_d.full = ~xmit;
                end else if (xmit) begin
                    chan_d.shreg = {chan_q.shreg[DATA_W-2:0], 1'b0};
                end
            end
        end

        // software access; a load is refused while a byte is moving
        if (wr_en && !chan_q.mact && !chan_q.sact) begin
            chan_d.shreg = wr_data;
            chan_d.full  = 1'b1;
        end
        if (rd_en) chan_d.full = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chan_q <= '0;
        else        chan_q <= chan_d;
    end

    ssc_irq u_irq (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (done),
        .clr  (pend_clr),
        .mask (irq_mask),
        .pend (pend),
        .irq  (irq)
    );

    assign rd_data  = chan_q.shreg;
    assign buf_full = chan_q.full;
    assign sc_o     = hs ? 1'b0 : chan_q.sclk;
    assign sc_oe    = en & (master ? (hs ? chan_q.sclk : 1'b1) : busy);
    assign sd_o     = chan_q.shreg[DATA_W-1];
    assign sd_oe    = en & xmit & (master ? chan_q.mact : (chan_q.full | chan_q.sact));

endmodule

// File: rtl/ssc_chk.sv
module ssc_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic en,
    input logic master,
    input logic xmit,
    input logic hs,
    input logic pend_clr,
    input logic buf_full,
    input logic pend,
    input logic sc_o,
    input logic sc_oe,
    input logic sd_o
);

    // R4
    clk_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && master && !hs && !tick) |=> $stable(sc_o));

    // R2
    tx_data_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && master && xmit && !hs && $rose(sc_o)) |-> $stable(sd_o));

    // R3
    rx_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && master && !xmit && !hs && buf_full && !sc_o) |=> !sc_o);

    // R5
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !pend_clr) |=> pend);

    // R9
    hs_busy_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !master && hs && !xmit && buf_full) |-> sc_oe);

    // R11
    off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !sc_o);

endmodule

bind sync_serial_chan ssc_chk u_ssc_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .en      (en),
    .master  (master),
    .xmit    (xmit),
    .hs      (hs),
    .pend_clr(pend_clr),
    .buf_full(buf_full),
    .pend    (pend),
    .sc_o    (sc_o),
    .sc_oe   (sc_oe),
    .sd_o    (sd_o)
);

// File: tb/sync_serial_chan_bench.sv
`timescale 1ns/1ps
module sync_serial_chan_bench;

    localparam int TDIV = 8;
    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick;
    logic       en = 0, master = 0, xmit = 0, hs = 0, irq_mask = 0, pend_clr = 0;
    logic       wr_en = 0, rd_en = 0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       buf_full, pend, irq;
    logic       sc_i, sc_o, sc_oe, sd_i = 0, sd_o, sd_oe;
    logic       ext_clk = 0, ext_pull = 0;
    logic [2:0] tcnt;
    int         total = 0, bad = 0;
    bit         finished = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            tcnt <= '0;
            tick <= 1'b0;
        end else begin
            tcnt <= tcnt + 3'd1;
            tick <= (tcnt == 3'(TDIV - 1));
        end
    end

    // pull-up model in handshaking mode; plain clock otherwise
    assign sc_i = hs ? ~((sc_oe & ~sc_o) | ext_pull) : ext_clk;

    sync_serial_chan u_sync_serial_chan (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .master(master), .xmit(xmit),
        .hs(hs), .irq_mask(irq_mask), .pend_clr(pend_clr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .buf_full(buf_full), .pend(pend), .irq(irq),
        .sc_i(sc_i), .sc_o(sc_o), .sc_oe(sc_oe), .sd_i(sd_i), .sd_o(sd_o), .sd_oe(sd_oe)
    );

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load(input logic [7:0] v);
        wr_data = v; wr_en = 1; step(); wr_en = 0;
    endtask

    task automatic clear_pend();
        pend_clr = 1; step(); pend_clr = 0;
    endtask

    task automatic t_reset();
        step(2);
        chk("R1 pend in reset", pend, 0);
        rst_n = 1; step(3);
        chk("R1 buf_full", buf_full, 0);
        chk("R1 pend/irq", {pend, irq}, 0);
        chk("R1 oe off", {sc_oe, sd_oe}, 0);
    endtask

    task automatic t_master_tx();
        logic [7:0] got = '0;
        int rises = 0, badint = 0, last = -1;
        logic prev;
        en = 0; master = 1; xmit = 1; hs = 0; irq_mask = 1; step();
        load(8'hA5); en = 1; prev = sc_o;
        for (int c = 0; c < 400; c++) begin
            step();
            wr_en = 0;
            if (sc_o !== prev) begin
                if (last >= 0 && c - last != TDIV) badint++;
                last = c;
            end
            if (sc_o && !prev) begin
                got = {got[6:0], sd_o}; rises++;
                if (rises == 2) begin wr_data = 8'h00; wr_en = 1; end
            end
            prev = sc_o;
            if (pend) break;
        end
        wr_en = 0;
        chk("R2 byte out", got, 8'hA5);
        chk("R2 pulses", rises, 8);
        chk("R2 idle low, data off", {sc_o, sd_oe}, 0);
        chk("R4 half period", badint, 0);
        chk("R5 pend/irq", {pend, irq}, 2'b11);
        chk("R5 tx empties", buf_full, 0);
        chk("R10 mid-byte write ignored", got, 8'hA5);
        en = 0; clear_pend();
        chk("R5 pend cleared", pend, 0);
    endtask

    task automatic t_master_rx();
        logic [7:0] d = 8'h3C;
        int idx = 7, rises = 0;
        logic prev;
        en = 0; master = 1; xmit = 0; hs = 0; irq_mask = 0; sd_i = d[7]; step();
        en = 1; prev = sc_o;
        for (int c = 0; c < 400; c++) begin
            step();
            if (prev && !sc_o) begin idx--; if (idx >= 0) sd_i = d[idx]; end
            prev = sc_o;
            if (pend) break;
        end
        chk("R3 byte in", rd_data, 8'h3C);
        chk("R3 full", buf_full, 1);
        chk("R5 masked irq", {pend, irq}, 2'b10);
        for (int c = 0; c < 40; c++) begin
            step();
            if (sc_o && !prev) rises++;
            prev = sc_o;
        end
        chk("R3 no start while full", rises, 0);
        en = 0; rd_en = 1; step(); rd_en = 0;
        chk("R3 read empties", buf_full, 0);
        clear_pend();
    endtask

    task automatic t_slave_rx();
        logic [7:0] d = 8'h96;
        en = 0; master = 0; xmit = 0; hs = 0; ext_clk = 0; step(); en = 1;
        for (int i = 7; i >= 0; i--) begin
            sd_i = d[i]; step(HALF); ext_clk = 1; step(HALF); ext_clk = 0;
        end
        step(8);
        chk("R6 byte in", rd_data, 8'h96);
        chk("R6 full/pend", {buf_full, pend}, 2'b11);
        rd_en = 1; step(); rd_en = 0; en = 0; clear_pend();
    endtask

    task automatic t_slave_tx();
        logic [7:0] got = '0;
        en = 0; master = 0; xmit = 1; hs = 0; ext_clk = 0; step();
        load(8'h5B); en = 1; step(2);
        chk("R7 msb ready", {sd_oe, sd_o}, 2'b10);
        for (int i = 0; i < 8; i++) begin
            step(HALF); got = {got[6:0], sd_o}; ext_clk = 1; step(HALF); ext_clk = 0;
        end
        step(HALF);
        chk("R7 byte out", got, 8'h5B);
        chk("R7 released", sd_oe, 0);
        chk("R7 empty/pend", {buf_full, pend}, 2'b01);
        en = 0; clear_pend();
    endtask

    task automatic t_hs_master();
        logic [7:0] got = '0;
        int falls = 0, scobad = 0, pulled = 0;
        logic prev;
        en = 0; master = 1; xmit = 1; hs = 1; ext_pull = 1; step();
        load(8'hC3); en = 1;
        for (int c = 0; c < 40; c++) begin step(); if (sc_oe) pulled++; end
        chk("R8 waits for line", pulled, 0);
        ext_pull = 0; prev = sc_i;
        for (int c = 0; c < 400; c++) begin
            step();
            if (prev && !sc_i) begin got = {got[6:0], sd_o}; falls++; end
            if (sc_o) scobad++;
            prev = sc_i;
            if (pend) break;
        end
        chk("R8 byte out", got, 8'hC3);
        chk("R8 pulses", falls, 8);
        chk("R8 released after", {sc_oe, sc_i}, 2'b01);
        chk("R12 open-drain", scobad, 0);
        en = 0; clear_pend();
    endtask

    task automatic t_hs_slave();
        logic [7:0] d = 8'h71;
        en = 0; master = 0; xmit = 0; hs = 1; ext_pull = 0; step(); en = 1; step(3);
        chk("R9 rx ready releases", sc_oe, 0);
        for (int i = 7; i >= 0; i--) begin
            sd_i = d[i]; step(HALF); ext_pull = 1; step(HALF); ext_pull = 0;
        end
        step(8);
        chk("R9 byte in", rd_data, 8'h71);
        chk("R9 rx full pulls low", {sc_oe, sc_i}, 2'b10);
        rd_en = 1; step(); rd_en = 0; step(4);
        chk("R9 rx read releases", {sc_oe, sc_i}, 2'b01);
        en = 0; xmit = 1; step(); en = 1; step(2);
        chk("R9 tx empty pulls low", sc_oe, 1);
        load(8'h11); step(2);
        chk("R9 tx loaded releases", sc_oe, 0);
        en = 0; step(); rd_en = 1; step(); rd_en = 0; clear_pend();
    endtask

    task automatic t_abort();
        en = 0; master = 1; xmit = 1; hs = 0; step();
        load(8'hFF); en = 1;
        for (int c = 0; c < 100; c++) begin step(); if (sc_o) break; end
        chk("R11 transfer running", {sc_o, sd_oe}, 2'b11);
        en = 0; step();
        chk("R11 abandoned", {sc_o, sc_oe, sd_oe}, 0);
        rd_en = 1; step(); rd_en = 0;
    endtask

    initial begin
        t_reset();
        t_master_tx();
        t_master_rx();
        t_slave_rx();
        t_slave_tx();
        t_hs_master();
        t_hs_slave();
        t_abort();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule